// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block sits between the instruction memory and the datapath of a small single-cycle processor. It reads the six-bit major opcode of each 32-bit instruction and, in the same cycle, drives every control point the datapath needs. These are the write-register choice, the second ALU operand choice, the immediate extender mode, the data-memory write, the write-back source, the register-file write and the next-PC choice. It also drives a two-bit ALU request code. Decoding is split across two levels. This block only names the class of ALU work. A separate local ALU decoder, outside this block, reads the funct field when the request says to defer to it.

Five instructions are recognised: register-register (R-type), OR with immediate, load word, store word and branch-if-equal. Every other opcode drives all outputs low. That setting writes nothing, stores nothing and falls through to the sequential PC, so an illegal word cannot change any architectural state. A parameter picks one of two decode variants with identical behaviour. One is a two-plane match-and-OR structure. The other is a lookup loop.

Top module: `main_ctrl_decoder`

## Requirements
- R1: The opcodes recognised are R-type 000000, OR-immediate 001101, load word 100011, store word 101011 and branch-if-equal 000100. The values are parameters, and these are the defaults.
- R2: `rf_wr` is 1 for R-type, OR-immediate and load word, and 0 for store word and branch-if-equal.
- R3: `rd_dest_sel` is 0 (select rt) for load word and OR-immediate, and 1 (select rd) for R-type, store word and branch-if-equal.
- R4: `alu_imm_sel` is 1 (immediate operand) for OR-immediate, load word and store word. It is 0 (register operand) for R-type and for branch-if-equal, because the branch compares two registers.
- R5: `ext_signed` is 0 (zero-extend) for OR-immediate and 1 (sign-extend) for the other four recognised opcodes.
- R6: `dmem_wr` is 1 only for store word, and `wb_from_mem` is 1 only for load word.
- R7: `pc_take_br` is 1 only for branch-if-equal.
- R8: `alu_class` encodes 00 = add (load word and store word), 01 = subtract (branch-if-equal), 10 = defer to funct (R-type) and 11 = OR (OR-immediate).
- R9: Any opcode outside R1 drives every output to 0: no register write, no memory write, sequential PC, add request.
- R10: The match-plane variant (IMPL=0) and the lookup variant (IMPL=1) give identical outputs for all 64 opcode values.
- R11: At most one of `rf_wr`, `dmem_wr` and `pc_take_br` is 1 for any opcode.
- R12: Outputs follow the opcode combinationally, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | OPC_W (6) | Major opcode field of the current instruction |
| rd_dest_sel | output | 1 | Write-register choice: 0 = rt, 1 = rd |
| alu_imm_sel | output | 1 | Second ALU operand: 0 = register, 1 = extended immediate |
| ext_signed | output | 1 | Immediate extender: 0 = zero, 1 = sign |
| dmem_wr | output | 1 | Data-memory write enable |
| wb_from_mem | output | 1 | Write-back source: 0 = ALU result, 1 = memory data |
| rf_wr | output | 1 | Register-file write enable |
| pc_take_br | output | 1 | Next PC: 0 = sequential, 1 = branch target when equal |
| alu_class | output | 2 | ALU request code for the local ALU decoder |

## Verification
The hardest case to reach is the unrecognised opcode, for two reasons. Opcodes that differ from a legal one in a single bit must still drive all outputs to zero, and the two decode variants must agree on every one of them. Directed vectors alone would hit only a few such codes. After the five legal opcodes are applied from a table, the stimulus sweeps all 64 opcode values through two instances, one of each variant. Each response is compared against a model written independently in the bench, so every near-miss code is covered for both variants.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [1:0] {
      ALU_ADD   = 2'b00,
      ALU_SUB   = 2'b01,
      ALU_FUNCT = 2'b10,
      ALU_OR    = 2'b11
   } alu_req_e;

   // control vector bit positions
   localparam int CTL_W  = 9;
   localparam int B_DST  = 8;
   localparam int B_BIMM = 7;
   localparam int B_EXT  = 6;
   localparam int B_MW   = 5;
   localparam int B_LD   = 4;
   localparam int B_RW   = 3;
   localparam int B_BR   = 2;
   localparam int B_AOP  = 0;   // two bits: [1:0]

   // instruction classes
   localparam int N_CLS   = 5;
   localparam int CLS_R   = 0;
   localparam int CLS_ORI = 1;
   localparam int CLS_LW  = 2;
   localparam int CLS_SW  = 3;
   localparam int CLS_BEQ = 4;

   typedef logic [CTL_W-1:0] ctl_vec_t;

   // one row of control settings per class: dst,bimm,ext,mw,ld,rw,br,aop
   function automatic ctl_vec_t class_row(input int cls);
      ctl_vec_t r;
      case (cls)
         CLS_R:   r = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, ALU_FUNCT};
         CLS_ORI: r = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ALU_OR};
         CLS_LW:  r = {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, ALU_ADD};
         CLS_SW:  r = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ALU_ADD};
         CLS_BEQ: r = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ALU_SUB};
         default: r = '0;
      endcase
      return r;
   endfunction

   // OR-plane column: which classes drive control bit b
   function automatic logic [N_CLS-1:0] bit_mask(input int b);
      logic [N_CLS-1:0] m;
      ctl_vec_t         row;
      for (int c = 0; c < N_CLS; c++) begin
         row  = class_row(c);
         m[c] = row[b];
      end
      return m;
   endfunction

endpackage

// File: rtl/mcd_opc_match.sv
module mcd_opc_match #(
   parameter int                    OPC_W = 6,
   parameter int                    N     = 5,
   parameter logic [N*OPC_W-1:0]    CODES = '0
) (
   input  logic [OPC_W-1:0] op_code,
   output logic [N-1:0]     hit
);

   // AND plane: one match line per instruction class
   for (genvar gi = 0; gi < N; gi++) begin : g_line
      localparam logic [OPC_W-1:0] CODE = CODES[gi*OPC_W +: OPC_W];
      assign hit[gi] = (op_code == CODE);
   end

endmodule

// File: rtl/mcd_ctl_plane.sv
module mcd_ctl_plane #(
   parameter int N = 5,
   parameter int W = 9
) (
   input  logic [N-1:0] hit,
   output logic [W-1:0] ctl
);

   // OR plane: each control bit collects the classes that set it
   for (genvar gb = 0; gb < W; gb++) begin : g_col
      localparam logic [N-1:0] MASK = mcd_pkg::bit_mask(gb);
      assign ctl[gb] = |(hit & MASK);
   end

endmodule

// File: rtl/mcd_lookup.sv
module mcd_lookup #(
   parameter int                    OPC_W = 6,
   parameter int                    N     = 5,
   parameter int                    W     = 9,
   parameter logic [N*OPC_W-1:0]    CODES = '0
) (
   input  logic [OPC_W-1:0] op_code,
   output logic [W-1:0]     ctl
);

   // codes are distinct (checked at the top), so loop order carries no priority
   always_comb begin
      ctl = '0;
      for (int c = 0; c < N; c++) begin
         if (op_code == CODES[c*OPC_W +: OPC_W]) ctl = mcd_pkg::class_row(c);
      end
   end

endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder #(
   parameter int               OPC_W     = 6,
   parameter int               IMPL      = 0,          // 0 = match planes, 1 = lookup
   parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
   parameter logic [OPC_W-1:0] OPC_ORI   = 6'b001101,
   parameter logic [OPC_W-1:0] OPC_LW    = 6'b100011,
   parameter logic [OPC_W-1:0] OPC_SW    = 6'b101011,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100
) (
   input  logic [OPC_W-1:0] op_code,
   output logic             rd_dest_sel,
   output logic             alu_imm_sel,
   output logic             ext_signed,
   output logic             dmem_wr,
   output logic             wb_from_mem,
   output logic             rf_wr,
   output logic             pc_take_br,
   output logic [1:0]       alu_class
);
   import mcd_pkg::*;

   localparam int NC = N_CLS;
   localparam int CW = CTL_W;
   localparam logic [NC*OPC_W-1:0] CODES = {OPC_BEQ, OPC_SW, OPC_LW, OPC_ORI, OPC_RTYPE};

   // elaboration-time parameter checks
   if (OPC_W < 3) begin : g_bad_w
      $error("main_ctrl_decoder: OPC_W too small for five distinct opcodes");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("main_ctrl_decoder: IMPL must be 0 or 1");
   end
   for (genvar ga = 0; ga < NC; ga++) begin : g_dist_a
      for (genvar gb = ga + 1; gb < NC; gb++) begin : g_dist_b
         if (CODES[ga*OPC_W +: OPC_W] == CODES[gb*OPC_W +: OPC_W]) begin : g_dup
            $error("main_ctrl_decoder: two instruction classes share one opcode");
         end
      end
   end

   ctl_vec_t ctl;

   if (IMPL == 0) begin : g_pla
      logic [NC-1:0] hit;
      mcd_opc_match #(.OPC_W(OPC_W), .N(NC), .CODES(CODES)) u_match (
         .op_code (op_code),
         .hit     (hit)
      );
      mcd_ctl_plane #(.N(NC), .W(CW)) u_plane (
         .hit (hit),
         .ctl (ctl)
      );
   end else begin : g_lut
      mcd_lookup #(.OPC_W(OPC_W), .N(NC), .W(CW), .CODES(CODES)) u_lut (
         .op_code (op_code),
         .ctl     (ctl)
      );
   end

   assign rd_dest_sel = ctl[B_DST];
   assign alu_imm_sel = ctl[B_BIMM];
   assign ext_signed  = ctl[B_EXT];
   assign dmem_wr     = ctl[B_MW];
   assign wb_from_mem = ctl[B_LD];
   assign rf_wr       = ctl[B_RW];
   assign pc_take_br  = ctl[B_BR];
   assign alu_class   = ctl[B_AOP +: 2];

endmodule

// File: rtl/main_ctrl_decoder_chk.sv
module main_ctrl_decoder_chk #(
   parameter int               OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_RTYPE = 6'b000000,
   parameter logic [OPC_W-1:0] OPC_ORI   = 6'b001101,
   parameter logic [OPC_W-1:0] OPC_LW    = 6'b100011,
   parameter logic [OPC_W-1:0] OPC_SW    = 6'b101011,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100
) (
   input logic [OPC_W-1:0] op_code,
   input logic             rd_dest_sel,
   input logic             alu_imm_sel,
   input logic             ext_signed,
   input logic             dmem_wr,
   input logic             wb_from_mem,
   input logic             rf_wr,
   input logic             pc_take_br,
   input logic [1:0]       alu_class
);

   logic known;
   assign known = (op_code == OPC_RTYPE) || (op_code == OPC_ORI) || (op_code == OPC_LW) ||
                  (op_code == OPC_SW) || (op_code == OPC_BEQ);

   always_comb begin
      if (!$isunknown(op_code)) begin
         p_one_effect_r11: assert ($onehot0({rf_wr, dmem_wr, pc_take_br}))
            else $error("more than one state-changing output active");
         p_unknown_safe_r9: assert (known || (!rf_wr && !dmem_wr && !pc_take_br && alu_class == 2'b00))
            else $error("unrecognised opcode changes state");
         p_store_only_r6: assert (!dmem_wr || (op_code == OPC_SW && !wb_from_mem))
            else $error("memory write outside store");
         p_branch_sub_r7: assert (!pc_take_br || (alu_class == 2'b01 && !alu_imm_sel))
            else $error("branch without register subtract");
         p_ori_zero_ext_r5: assert (op_code != OPC_ORI || (!ext_signed && alu_class == 2'b11))
            else $error("OR-immediate not zero-extended OR");
         p_rt_dest_r3: assert (!(rf_wr && !rd_dest_sel) || op_code == OPC_LW || op_code == OPC_ORI)
            else $error("rt destination on wrong instruction");
      end
   end

endmodule

bind main_ctrl_decoder main_ctrl_decoder_chk #(
   .OPC_W(OPC_W), .OPC_RTYPE(OPC_RTYPE), .OPC_ORI(OPC_ORI),
   .OPC_LW(OPC_LW), .OPC_SW(OPC_SW), .OPC_BEQ(OPC_BEQ)
) u_chk (
   .op_code     (op_code),
   .rd_dest_sel (rd_dest_sel),
   .alu_imm_sel (alu_imm_sel),
   .ext_signed  (ext_signed),
   .dmem_wr     (dmem_wr),
   .wb_from_mem (wb_from_mem),
   .rf_wr       (rf_wr),
   .pc_take_br  (pc_take_br),
   .alu_class   (alu_class)
);

// File: tb/main_ctrl_decoder_bench.sv
`timescale 1ns/1ps
module main_ctrl_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] op = 6'b111111;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   logic       a_dst, a_bimm, a_ext, a_mw, a_ld, a_rw, a_br;
   logic [1:0] a_aop;
   logic       b_dst, b_bimm, b_ext, b_mw, b_ld, b_rw, b_br;
   logic [1:0] b_aop;

   main_ctrl_decoder #(.IMPL(0)) u_main_ctrl_decoder (
      .op_code(op), .rd_dest_sel(a_dst), .alu_imm_sel(a_bimm), .ext_signed(a_ext),
      .dmem_wr(a_mw), .wb_from_mem(a_ld), .rf_wr(a_rw), .pc_take_br(a_br), .alu_class(a_aop));

   main_ctrl_decoder #(.IMPL(1)) u_main_ctrl_decoder_lut (
      .op_code(op), .rd_dest_sel(b_dst), .alu_imm_sel(b_bimm), .ext_signed(b_ext),
      .dmem_wr(b_mw), .wb_from_mem(b_ld), .rf_wr(b_rw), .pc_take_br(b_br), .alu_class(b_aop));

   wire [8:0] got_a = {a_dst, a_bimm, a_ext, a_mw, a_ld, a_rw, a_br, a_aop};
   wire [8:0] got_b = {b_dst, b_bimm, b_ext, b_mw, b_ld, b_rw, b_br, b_aop};

   // {opcode, expected dst,bimm,ext,mw,ld,rw,br,aop[1:0]}
   localparam logic [14:0] VEC [5] = '{
      {6'b000000, 9'b1_0_1_0_0_1_0_10},   // R-type
      {6'b001101, 9'b0_1_0_0_0_1_0_11},   // OR-immediate
      {6'b100011, 9'b0_1_1_0_1_1_0_00},   // load
      {6'b101011, 9'b1_1_1_1_0_0_0_00},   // store
      {6'b000100, 9'b1_0_1_0_0_0_1_01}    // branch
   };

   function automatic logic [8:0] model(input logic [5:0] o);
      case (o)
         6'b000000: return 9'b101001010;
         6'b001101: return 9'b010001011;
         6'b100011: return 9'b011011000;
         6'b101011: return 9'b111100000;
         6'b000100: return 9'b101000101;
         default:   return 9'b000000000;
      endcase
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%b actual=%b expected=%b", req, op, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // reset state: bench holds an undefined opcode while in reset (R9)
      repeat (3) @(negedge clk);
      #1 check("R9 reset-state", got_a, 9'b0);
      check("R9 reset-state lut", got_b, 9'b0);
      @(negedge clk) rst_n = 1'b1;

      // table of legal opcodes: R1..R8
      for (int i = 0; i < 5; i++) begin
         @(negedge clk) op = VEC[i][14:9];
         #1;
         check("R1-R8 table", got_a, VEC[i][8:0]);
         check("R1 R2 R3 R4 R5 R6 R7 R8 table lut", got_b, VEC[i][8:0]);
      end

      // R12: response within the same time step, no clock edge between
      @(negedge clk) op = 6'b100011;
      #0.5 op = 6'b101011;
      #0.5 check("R12 combinational", got_a, 9'b111100000);

      // near-miss codes, one bit off a legal opcode (R9)
      @(negedge clk) op = 6'b001100;
      #1 check("R9 near ori", got_a, 9'b0);
      @(negedge clk) op = 6'b100111;
      #1 check("R9 near lw", got_a, 9'b0);
      @(negedge clk) op = 6'b000101;
      #1 check("R9 near beq", got_a, 9'b0);

      // full sweep of both variants against the model (R9, R10, R11)
      for (int k = 0; k < 64; k++) begin
         logic [8:0] e;
         @(negedge clk) op = 6'(k);
         #1;
         e = model(op);
         check("R10 sweep plane", got_a, e);
         check("R10 sweep lookup", got_b, e);
         n_chk++;
         if ($countones({a_rw, a_mw, a_br}) > 1) begin
            n_bad++;
            $display("FAIL R11 op=%b actual=%b expected=at most one", op, {a_rw, a_mw, a_br});
         end
      end
      finish_run();
   end

endmodule